// File: doc/BRIEF.md
# Vector AES-128 Full-Encryption Unit

This execution unit performs a complete AES-128 encryption on each active 128-bit element group of a vector register. The destination operand carries the plaintext groups in and receives the ciphertext groups back in place. The second source operand carries one 128-bit cipher key for each group. Only whole element groups below the vector length are processed, and there is no mask input.

Each group's 128 bits are four 32-bit elements. State byte 0 is the least significant byte of element 0, so AES byte k sits at bits [8k+7:8k] of the group, and the result uses the same byte order. Group i occupies bits [128i+127:128i] of a register. After a start, the unit takes a snapshot of both operands. It XORs the first group with its key. It then runs one round per clock. In each round the key schedule first advances one step (RotWord, SubWord and the round constant applied to the last word), and the round then uses the new round key. Rounds 1 to 9 are full rounds and round 10 omits MixColumns. Each finished group comes out on a write-back port together with its group index. The next group's initial XOR is loaded in the same cycle, so every group costs ten cycles.

Top module: `aes128_vec_unit`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff (bytes in AES order, byte 0 in the low byte of the group), the written-back group is 69c4e0d86a7b0430d8cdb78070b4c55a. The other public test vectors also produce their published ciphertexts.
- R2: For a legal vl, exactly vl/4 groups are written back. The groups come out in ascending index order. wb_idx_o = i carries the encryption of vd group i under vs2 group i, and groups at or above vl/4 are never written.
- R3: Take the clock edge that accepts start as edge 0. The write-back of group g is presented in the cycle after edge 10·(g+1).
- R4: done_o is high for exactly one cycle, in the cycle after the last write-back. busy_o is high from the accepting edge until done_o rises, and is low while done_o is high.
- R5: vl = 0 produces no write-back. done_o is high with err_o low in the cycle after the accepting edge.
- R6: A vl that is not a multiple of 4, or that is larger than 4·NUM_GROUPS, is illegal. It produces no write-back, and done_o and err_o are both high in the cycle after the accepting edge.
- R7: A start_i asserted while busy_o is high is ignored. The operation in progress finishes unchanged and no second operation begins.
- R8: vd_i, vs2_i and vl_i are only sampled on the accepting edge. Changing them during an operation has no effect on the results.
- R9: After reset, busy_o, done_o, err_o and wb_valid_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when not busy |
| vl_i | input | VL_W | Vector length in 32-bit elements |
| vd_i | input | NUM_GROUPS·128 | Plaintext register contents |
| vs2_i | input | NUM_GROUPS·128 | Key register contents, one key per group |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Illegal vl, valid together with done_o |
| wb_valid_o | output | 1 | Write-back strobe for one group |
| wb_idx_o | output | IDX_W | Group index being written |
| wb_data_o | output | 128 | Ciphertext of that group |

## Verification
The checker counts cycles and write-backs from the accepting edge, which it recognises as start_i high while busy_o is low. It therefore assumes that the ports start from reset and that vl_i is valid on that edge. The bench drives every input on the falling edge. It holds start_i for exactly one cycle, except in the deliberate busy-time retrigger, and it changes the operands mid-operation only to show that they are ignored. All ciphertexts are checked against published AES-128 answers, not against a second model.

// File: rtl/aes128_vec_pkg.sv
package aes128_vec_pkg;

  localparam int unsigned GRP_BITS = 128;
  localparam int unsigned LAST_RND = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} fsm_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] t;
    acc = 8'h00;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = xtime(t);
    end
    return acc;
  endfunction

  // a^254 is the field inverse (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] e;
    r    = 8'h01;
    base = a;
    e    = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_f(input logic [7:0] a);
    logic [7:0] b;
    b = gf_inv(a);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  // round constant for key step rnd (1..10)
  function automatic logic [7:0] rcon_f(input logic [3:0] rnd);
    logic [7:0] v;
    v = 8'h01;
    for (int i = 2; i <= 10; i++) begin
      if (i <= int'(rnd)) v = xtime(v);
    end
    return v;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox import aes128_vec_pkg::*; (
  input  logic [7:0] a_i,
  output logic [7:0] s_o
);
  assign s_o = sbox_f(a_i);
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step (
  input  logic [127:0] key_i,
  input  logic [7:0]   rcon_i,
  output logic [127:0] key_o
);
  logic [31:0] rot_w, sub_w;
  logic [31:0] w0, w1, w2, w3;

  // word byte 0 is the low byte; rotate left by one byte in AES order
  assign rot_w = {key_i[103:96], key_i[127:104]};

  for (genvar b = 0; b < 4; b++) begin : g_sub
    aes_sbox u_sbox (.a_i(rot_w[8*b +: 8]), .s_o(sub_w[8*b +: 8]));
  end

  assign w0 = key_i[31:0]  ^ sub_w ^ {24'h0, rcon_i};
  assign w1 = key_i[63:32] ^ w0;
  assign w2 = key_i[95:64] ^ w1;
  assign w3 = key_i[127:96] ^ w2;

  assign key_o = {w3, w2, w1, w0};
endmodule

// File: rtl/aes_round_core.sv
module aes_round_core import aes128_vec_pkg::*; (
  input  logic [127:0] state_i,
  input  logic [127:0] key_i,
  input  logic         final_i,
  output logic [127:0] state_o
);
  logic [127:0] sb, sr, mc;

  for (genvar i = 0; i < 16; i++) begin : g_sub
    aes_sbox u_sbox (.a_i(state_i[8*i +: 8]), .s_o(sb[8*i +: 8]));
  end

  // byte (row r, col c) sits at index 4c+r
  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr[8*(4*c+r) +: 8] = sb[8*(4*((c+r)%4)+r) +: 8];
    end

    logic [7:0] a0, a1, a2, a3;
    assign a0 = sr[32*c +: 8];
    assign a1 = sr[32*c+8 +: 8];
    assign a2 = sr[32*c+16 +: 8];
    assign a3 = sr[32*c+24 +: 8];

    assign mc[32*c +: 8]    = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mc[32*c+8 +: 8]  = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mc[32*c+16 +: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mc[32*c+24 +: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign state_o = (final_i ? sr : mc) ^ key_i;
endmodule

// File: rtl/aes128_vec_unit.sv
module aes128_vec_unit import aes128_vec_pkg::*; #(
  parameter  int unsigned NUM_GROUPS = 4,
  parameter  int unsigned VL_W       = 8,
  localparam int unsigned VLEN       = NUM_GROUPS * GRP_BITS,
  localparam int unsigned IDX_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic [VLEN-1:0]      vd_i,
  input  logic [VLEN-1:0]      vs2_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 wb_valid_o,
  output logic [IDX_W-1:0]     wb_idx_o,
  output logic [GRP_BITS-1:0]  wb_data_o
);
  localparam logic [VL_W-1:0] VL_MAX = VL_W'(4 * NUM_GROUPS);

  fsm_e                fsm_q;
  logic [VLEN-1:0]     vd_q, key_q;
  logic [IDX_W-1:0]    grp_q, last_q, grp_nxt;
  logic [3:0]          rnd_q;
  logic [127:0]        st_q, rk_q, rk_nxt, st_nxt;
  logic [127:0]        nxt_pt, nxt_key;
  logic [7:0]          rcon;
  logic [VL_W-1:0]     n_grp;
  logic                accept, vl_ok, vl_zero, rnd_last, grp_last;
  logic                wb_valid_q, done_q, err_q;
  logic [IDX_W-1:0]    wb_idx_q;
  logic [127:0]        wb_data_q;

  assign accept   = start_i && (fsm_q == ST_IDLE);
  assign vl_ok    = (vl_i[1:0] == 2'b00) && (vl_i <= VL_MAX);
  assign vl_zero  = (vl_i == '0);
  assign n_grp    = vl_i >> 2;
  assign rnd_last = (rnd_q == 4'(LAST_RND));
  assign grp_last = (grp_q == last_q);
  assign grp_nxt  = grp_q + IDX_W'(1);
  assign nxt_pt   = vd_q[int'(grp_nxt)*GRP_BITS +: GRP_BITS];
  assign nxt_key  = key_q[int'(grp_nxt)*GRP_BITS +: GRP_BITS];
  assign rcon     = rcon_f(rnd_q);

  aes_key_step u_key_step (
    .key_i  (rk_q),
    .rcon_i (rcon),
    .key_o  (rk_nxt)
  );

  aes_round_core u_round (
    .state_i (st_q),
    .key_i   (rk_nxt),
    .final_i (rnd_last),
    .state_o (st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= ST_IDLE;
      vd_q       <= '0;
      key_q      <= '0;
      grp_q      <= '0;
      last_q     <= '0;
      rnd_q      <= '0;
      st_q       <= '0;
      rk_q       <= '0;
      wb_valid_q <= 1'b0;
      wb_idx_q   <= '0;
      wb_data_q  <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      wb_valid_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      unique case (fsm_q)
        ST_IDLE: begin
          if (accept) begin
            if (!vl_ok) begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end else if (vl_zero) begin
              done_q <= 1'b1;
            end else begin
              vd_q   <= vd_i;
              key_q  <= vs2_i;
              last_q <= IDX_W'(n_grp - VL_W'(1));
              grp_q  <= '0;
              rnd_q  <= 4'd1;
              st_q   <= vd_i[GRP_BITS-1:0] ^ vs2_i[GRP_BITS-1:0];
              rk_q   <= vs2_i[GRP_BITS-1:0];
              fsm_q  <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (rnd_last) begin
            wb_valid_q <= 1'b1;
            wb_idx_q   <= grp_q;
            wb_data_q  <= st_nxt;
            if (grp_last) begin
              fsm_q <= ST_DRAIN;
            end else begin
              // next group's initial AddRoundKey overlaps the final round
              grp_q <= grp_nxt;
              rnd_q <= 4'd1;
              st_q  <= nxt_pt ^ nxt_key;
              rk_q  <= nxt_key;
            end
          end else begin
            rnd_q <= rnd_q + 4'd1;
            st_q  <= st_nxt;
            rk_q  <= rk_nxt;
          end
        end
        ST_DRAIN: begin
          done_q <= 1'b1;
          fsm_q  <= ST_IDLE;
        end
        default: fsm_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (fsm_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign wb_valid_o = wb_valid_q;
  assign wb_idx_o   = wb_idx_q;
  assign wb_data_o  = wb_data_q;
endmodule

// File: rtl/aes128_vec_unit_chk.sv
module aes128_vec_unit_chk #(
  parameter  int unsigned NUM_GROUPS = 4,
  parameter  int unsigned VL_W       = 8,
  localparam int unsigned IDX_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [VL_W-1:0]  vl_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             wb_valid_o,
  input logic [IDX_W-1:0] wb_idx_o
);
  logic [15:0]     cyc_q;
  logic [VL_W-1:0] wb_cnt_q, exp_n_q;
  logic            acc;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q    <= '0;
      wb_cnt_q <= '0;
      exp_n_q  <= '0;
    end else if (acc) begin
      cyc_q    <= '0;
      wb_cnt_q <= '0;
      exp_n_q  <= vl_i >> 2;
    end else begin
      if (busy_o) cyc_q <= cyc_q + 16'd1;
      if (wb_valid_o) wb_cnt_q <= wb_cnt_q + VL_W'(1);
    end
  end

  // R2
  wb_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (VL_W'(wb_idx_o) == wb_cnt_q));

  // R3
  wb_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (int'(cyc_q) == 10 * (int'(wb_cnt_q) + 1)));

  // R4
  done_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (wb_cnt_q == exp_n_q));

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && (wb_cnt_q == '0)));

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind aes128_vec_unit aes128_vec_unit_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .VL_W       (VL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .vl_i       (vl_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .wb_valid_o (wb_valid_o),
  .wb_idx_o   (wb_idx_o)
);

// File: tb/aes128_vec_unit_test.sv
module aes128_vec_unit_test;
  localparam int unsigned NG    = 4;
  localparam int unsigned VL_W  = 8;
  localparam int unsigned VLEN  = NG * 128;
  localparam int unsigned IDX_W = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [VL_W-1:0]  vl_i = '0;
  logic [VLEN-1:0]  vd_i = '0;
  logic [VLEN-1:0]  vs2_i = '0;
  logic             busy_o, done_o, err_o, wb_valid_o;
  logic [IDX_W-1:0] wb_idx_o;
  logic [127:0]     wb_data_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  aes128_vec_unit #(.NUM_GROUPS(NG), .VL_W(VL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vl_i(vl_i),
    .vd_i(vd_i), .vs2_i(vs2_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .wb_valid_o(wb_valid_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o)
  );

  // vectors written in AES byte order, byte 0 first
  function automatic logic [127:0] rev16(input logic [127:0] x);
    logic [127:0] y;
    for (int i = 0; i < 16; i++) y[8*i +: 8] = x[8*(15-i) +: 8];
    return y;
  endfunction

  logic [127:0] k1, p1, c1, k2, p2, c2, k3, p3, c3;
  initial begin
    k1 = rev16(128'h000102030405060708090a0b0c0d0e0f);
    p1 = rev16(128'h00112233445566778899aabbccddeeff);
    c1 = rev16(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    k2 = rev16(128'h2b7e151628aed2a6abf7158809cf4f3c);
    p2 = rev16(128'h3243f6a8885a308d313198a2e0370734);
    c2 = rev16(128'h3925841d02dc09fbdc118597196a0b32);
    k3 = '0;
    p3 = '0;
    c3 = rev16(128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
  end

  // results of the last run
  logic [127:0] res_data [4];
  int           res_idx  [4];
  int           res_cyc  [4];
  int           wb_n;
  int           done_k;
  logic         err_seen;
  logic         busy_at0;
  logic         done_after;
  logic         busy_during_done;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int vl, input logic [VLEN-1:0] vd,
                        input logic [VLEN-1:0] ks, input bit disturb);
    wb_n = 0; done_k = -1; err_seen = 1'b0; done_after = 1'b0; busy_during_done = 1'b0;
    @(negedge clk);
    start_i = 1'b1; vl_i = VL_W'(vl); vd_i = vd; vs2_i = ks;
    @(negedge clk);
    start_i = 1'b0;
    busy_at0 = busy_o;
    for (int k = 0; k < 80; k++) begin
      if (wb_valid_o) begin
        if (wb_n < 4) begin
          res_data[wb_n] = wb_data_o;
          res_idx[wb_n]  = int'(wb_idx_o);
          res_cyc[wb_n]  = k;
        end
        wb_n++;
      end
      if (done_o) begin
        done_k = k;
        err_seen = err_o;
        busy_during_done = busy_o;
        break;
      end
      if (disturb && k == 3) begin
        start_i = 1'b1; vl_i = VL_W'(8); vd_i = ~vd; vs2_i = ~ks;
      end
      if (disturb && k == 4) start_i = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    done_after = done_o;
    vd_i = '0; vs2_i = '0; vl_i = '0;
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !err_o && !wb_valid_o, "R9", "outputs after reset",
        {busy_o, done_o, err_o, wb_valid_o}, 0);
  endtask

  task automatic t_known_answer();
    run_op(4, {128'hdead, 128'hbeef, 128'h1234, p1}, {k3, k2, k1, k1}, 1'b0);
    chk(wb_n == 1, "R1", "wb count", wb_n, 1);
    chk(res_data[0] == c1, "R1", "ciphertext", res_data[0], c1);
    chk(res_idx[0] == 0, "R2", "index", res_idx[0], 0);
    chk(res_cyc[0] == 10, "R3", "wb cycle", res_cyc[0], 10);
    chk(done_k == 11 && !err_seen, "R4", "done cycle", done_k, 11);
    chk(busy_at0 && !busy_during_done && !done_after, "R4", "busy/done shape",
        {busy_at0, busy_during_done, done_after}, 3'b100);
  endtask

  task automatic t_three_groups();
    run_op(12, {128'hffff, p1, p3, p2}, {k1, k1, k3, k2}, 1'b0);
    chk(wb_n == 3, "R2", "wb count", wb_n, 3);
    chk(res_data[0] == c2, "R1", "group0 data", res_data[0], c2);
    chk(res_data[1] == c3, "R1", "group1 data", res_data[1], c3);
    chk(res_data[2] == c1, "R2", "group2 data", res_data[2], c1);
    chk(res_idx[0] == 0 && res_idx[1] == 1 && res_idx[2] == 2, "R2", "order",
        {res_idx[0][7:0], res_idx[1][7:0], res_idx[2][7:0]}, 24'h000102);
    chk(res_cyc[1] == 20 && res_cyc[2] == 30, "R3", "wb cycles",
        {res_cyc[1][15:0], res_cyc[2][15:0]}, {16'd20, 16'd30});
    chk(done_k == 31, "R4", "done cycle", done_k, 31);
  endtask

  task automatic t_full_reg();
    run_op(16, {p3, p2, p1, p1}, {k3, k2, k1, k1}, 1'b0);
    chk(wb_n == 4, "R2", "wb count", wb_n, 4);
    chk(res_data[0] == c1 && res_data[1] == c1, "R2", "groups 0/1", res_data[1], c1);
    chk(res_data[3] == c3 && res_idx[3] == 3, "R2", "group3", res_data[3], c3);
    chk(res_cyc[3] == 40 && done_k == 41, "R3", "last wb/done", res_cyc[3], 40);
  endtask

  task automatic t_vl_zero();
    run_op(0, {4{p1}}, {4{k1}}, 1'b0);
    chk(wb_n == 0, "R5", "wb count", wb_n, 0);
    chk(done_k == 0 && !err_seen, "R5", "done/err", {done_k[7:0], 7'd0, err_seen}, 16'h0000);
  endtask

  task automatic t_illegal();
    run_op(6, {4{p1}}, {4{k1}}, 1'b0);
    chk(wb_n == 0 && done_k == 0 && err_seen, "R6", "vl=6", {wb_n[7:0], done_k[7:0], 7'd0, err_seen}, 24'h000001);
    run_op(20, {4{p1}}, {4{k1}}, 1'b0);
    chk(wb_n == 0 && done_k == 0 && err_seen, "R6", "vl=20", {wb_n[7:0], done_k[7:0], 7'd0, err_seen}, 24'h000001);
    run_op(4, {4{p2}}, {4{k2}}, 1'b0);
    chk(wb_n == 1 && res_data[0] == c2 && !err_seen, "R6", "legal after error", res_data[0], c2);
  endtask

  task automatic t_busy_retrigger();
    run_op(4, {128'h0, 128'h0, 128'h0, p1}, {128'h0, 128'h0, 128'h0, k1}, 1'b1);
    chk(wb_n == 1, "R7", "wb count with retrigger", wb_n, 1);
    chk(done_k == 11 && !done_after, "R7", "done cycle", done_k, 11);
    chk(res_data[0] == c1, "R8", "operands changed mid-run", res_data[0], c1);
    @(negedge clk);
    chk(!busy_o && !wb_valid_o, "R7", "no second operation", {busy_o, wb_valid_o}, 0);
  endtask

  initial begin
    #2_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_answer();
    t_three_groups();
    t_full_reg();
    t_vl_zero();
    t_illegal();
    t_busy_retrigger();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule